// File: doc/BRIEF.md
# Multiplexed Grid Scan Timing Generator

This block produces the time-multiplexed grid enables for a sixteen-digit fluorescent dot-matrix display. It runs from the oscillator clock and divides it into time units of eight clocks. It then builds a frame of fixed length: sixteen digit slots of sixty-four units each. During a slot, exactly one grid line may be driven. The block also reports which digit the current slot belongs to and whether the segment lines may carry data at that moment. A separate segment generator uses the digit index and the valid strobe to put the right pattern on the anodes.

Two 4-bit settings shape the picture. The brightness code sets how long the grid stays on inside each slot, in sixteenths of a slot. Every slot always keeps a blank tail. The digit-count code limits how many leading digits are lit. Slots past that count stay dark, so the frame period, and with it the refresh rate, never changes. Both settings are captured only at a frame boundary. A change written mid-frame therefore cannot cut a slot short or lengthen it.

Top module: `grid_scan_gen`

## Requirements
- R1: One time unit is 8 clocks. A digit slot is 64 units, so `digit_idx` holds each value for exactly 512 clocks.
- R2: `digit_idx` steps 0,1,...,15 and wraps to 0. One frame is 16 slots, 8192 clocks, whatever the settings.
- R3: With brightness code n (1 to 15, `duty_code` bit 0 = LSB), the grid of an enabled digit is on for the first 4n units (32n clocks) of its slot and off for the rest.
- R4: Brightness code 0 keeps every grid line and `disp_valid` low for the whole frame.
- R5: At code 15 a slot is lit for 60 units (480 clocks) and blank for the last 4 units (32 clocks). No grid is ever on in the last 4 units of a slot.
- R6: Digit-count code k from 1 to 15 lights only digits 0 to k-1. The slots of digits k to 15 stay dark and keep their length.
- R7: Digit-count code 0 lights all 16 digits.
- R8: At most one grid line is high. When one is high, it is bit `digit_idx` of `grid` (bit 0 is the first digit), and `disp_valid` is high exactly when a grid line is high.
- R9: Settings are sampled at the clock edge that ends a frame. A change applied during a frame leaves the rest of that frame unchanged and takes effect from the next frame.
- R10: While `rst_n` is low, `grid` is all zero, `disp_valid` is low and `digit_idx` is 0. The first frame after reset runs with both settings at 0, so it is dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_code | input | 4 | Brightness code, on-time in sixteenths of a slot |
| digit_count | input | 4 | Number of lit digits, 0 selects all 16 |
| grid | output | 16 | One-hot grid enables, bit 0 is the first digit |
| digit_idx | output | 4 | Index of the digit owning the current slot |
| disp_valid | output | 1 | High while the current grid is on, so segments may be driven |

## Verification
The bench compares full frames against a clock-count model. It goes after the last lit clock of a slot at the top brightness, where an off-by-one compare would eat into the 32-clock blank gap or light the first blank clock. It checks the count limit at 3 and at 15, and the all-digits value 0. Here a wrong range test either lights the sixteenth digit or darkens digit 0, and a design that shortened the frame for fewer digits would show a wrap sooner than 8192 clocks. A setting written in the middle of a frame must leave later slots of that frame alone. A design that applies settings at once would light a slot past the old count before the boundary.

// File: rtl/grid_scan_pkg.sv
package grid_scan_pkg;

  // Units per brightness step: a slot split into equal steps.
  function automatic int unsigned step_units(input int unsigned units_per_slot,
                                             input int unsigned steps);
    return units_per_slot / steps;
  endfunction

  // Lit units for a brightness code, counted from the slot start.
  function automatic int unsigned lit_units(input int unsigned code,
                                            input int unsigned per_step);
    return code * per_step;
  endfunction

  // Whether a digit lies inside the programmed count (0 = all digits).
  function automatic logic digit_in_range(input int unsigned digit,
                                          input int unsigned count_code);
    return (count_code == 0) || (digit < count_code);
  endfunction

endpackage

// File: rtl/grid_scan_prescale.sv
module grid_scan_prescale #(
  parameter int DIV = 8,
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/grid_scan_slots.sv
module grid_scan_slots #(
  parameter int UNITS  = 64,
  parameter int DIGITS = 16,
  localparam int UW = $clog2(UNITS),
  localparam int DW = $clog2(DIGITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unit_tick,
  output logic [UW-1:0] unit_pos,
  output logic [DW-1:0] digit,
  output logic          frame_end
);
  localparam logic [UW-1:0] LAST_UNIT  = UW'(UNITS - 1);
  localparam logic [DW-1:0] LAST_DIGIT = DW'(DIGITS - 1);

  logic slot_end;

  assign slot_end  = unit_tick && (unit_pos == LAST_UNIT);
  assign frame_end = slot_end && (digit == LAST_DIGIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_pos <= '0;
      digit    <= '0;
    end else if (unit_tick) begin
      if (unit_pos == LAST_UNIT) begin
        unit_pos <= '0;
        digit    <= (digit == LAST_DIGIT) ? '0 : digit + 1'b1;
      end else begin
        unit_pos <= unit_pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/grid_scan_cfg.sv
module grid_scan_cfg #(
  parameter int DUTY_W = 4,
  parameter int DIG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic [DIG_W-1:0]  count_in,
  output logic [DUTY_W-1:0] duty_now,
  output logic [DIG_W-1:0]  count_now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_now  <= '0;
      count_now <= '0;
    end else if (frame_end) begin
      duty_now  <= duty_in;
      count_now <= count_in;
    end
  end
endmodule

// File: rtl/grid_scan_decode.sv
module grid_scan_decode
  import grid_scan_pkg::*;
#(
  parameter int DIGITS   = 16,
  parameter int UW       = 6,
  parameter int DUTY_W   = 4,
  parameter int PER_STEP = 4,
  localparam int DW = $clog2(DIGITS)
) (
  input  logic [UW-1:0]     unit_pos,
  input  logic [DW-1:0]     digit,
  input  logic [DUTY_W-1:0] duty_now,
  input  logic [DW-1:0]     count_now,
  output logic [DIGITS-1:0] grid,
  output logic              lit
);
  always_comb begin
    lit = digit_in_range(32'(digit), 32'(count_now)) &&
          (32'(unit_pos) < lit_units(32'(duty_now), PER_STEP));
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_line
    assign grid[g] = lit && (digit == DW'(g));
  end
endmodule

// File: rtl/grid_scan_gen.sv
module grid_scan_gen
  import grid_scan_pkg::*;
#(
  parameter int CLKS_PER_UNIT  = 8,
  parameter int UNITS_PER_SLOT = 64,
  parameter int NUM_DIGITS     = 16,
  parameter int DUTY_STEPS     = 16,
  localparam int DIG_W  = $clog2(NUM_DIGITS),
  localparam int DUTY_W = $clog2(DUTY_STEPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DUTY_W-1:0]     duty_code,
  input  logic [DIG_W-1:0]      digit_count,
  output logic [NUM_DIGITS-1:0] grid,
  output logic [DIG_W-1:0]      digit_idx,
  output logic                  disp_valid
);
  localparam int UNIT_W   = $clog2(UNITS_PER_SLOT);
  localparam int PER_STEP = step_units(UNITS_PER_SLOT, DUTY_STEPS);

  // Named internal events, also watched by the bound checker.
  logic              unit_tick;
  logic              frame_end;
  logic [UNIT_W-1:0] unit_pos;
  logic [DUTY_W-1:0] duty_now;
  logic [DIG_W-1:0]  count_now;

  grid_scan_prescale #(.DIV(CLKS_PER_UNIT)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (unit_tick)
  );

  grid_scan_slots #(.UNITS(UNITS_PER_SLOT), .DIGITS(NUM_DIGITS)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .unit_tick(unit_tick),
    .unit_pos (unit_pos),
    .digit    (digit_idx),
    .frame_end(frame_end)
  );

  grid_scan_cfg #(.DUTY_W(DUTY_W), .DIG_W(DIG_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_end(frame_end),
    .duty_in  (duty_code),
    .count_in (digit_count),
    .duty_now (duty_now),
    .count_now(count_now)
  );

  grid_scan_decode #(
    .DIGITS  (NUM_DIGITS),
    .UW      (UNIT_W),
    .DUTY_W  (DUTY_W),
    .PER_STEP(PER_STEP)
  ) u_dec (
    .unit_pos (unit_pos),
    .digit    (digit_idx),
    .duty_now (duty_now),
    .count_now(count_now),
    .grid     (grid),
    .lit      (disp_valid)
  );
endmodule

// File: rtl/grid_scan_checker.sv
module grid_scan_checker #(
  parameter int CLKS_PER_UNIT  = 8,
  parameter int UNITS_PER_SLOT = 64,
  parameter int NUM_DIGITS     = 16,
  parameter int DUTY_STEPS     = 16,
  localparam int DIG_W  = $clog2(NUM_DIGITS),
  localparam int DUTY_W = $clog2(DUTY_STEPS),
  localparam int UNIT_W = $clog2(UNITS_PER_SLOT),
  localparam int TW     = (CLKS_PER_UNIT > 1) ? $clog2(CLKS_PER_UNIT) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_DIGITS-1:0] grid,
  input logic [DIG_W-1:0]      digit_idx,
  input logic                  disp_valid,
  input logic                  unit_tick,
  input logic                  frame_end,
  input logic [UNIT_W-1:0]     unit_pos,
  input logic [DUTY_W-1:0]     duty_now,
  input logic [DIG_W-1:0]      count_now
);
  localparam int MAX_ON = (DUTY_STEPS - 1) * (UNITS_PER_SLOT / DUTY_STEPS);

  logic [TW-1:0] since_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          since_tick <= '0;
    else if (unit_tick)  since_tick <= '0;
    else                 since_tick <= since_tick + 1'b1;
  end

  assert_unit_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    unit_tick |-> (since_tick == TW'(CLKS_PER_UNIT - 1)));

  assert_digit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_idx != $past(digit_idx)) |-> (digit_idx == DIG_W'($past(digit_idx) + 1'b1)));

  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (digit_idx == '0) && (unit_pos == '0));

  assert_dark_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_now == '0) |-> !disp_valid);

  assert_blank_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (32'(unit_pos) < MAX_ON));

  assert_count_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((count_now != '0) && (digit_idx >= count_now)) |-> (grid == '0));

  assert_grid_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grid));

  assert_grid_matches_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid == (grid == (NUM_DIGITS'(1) << digit_idx)));

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(duty_now) && $stable(count_now));

  assert_reset_dark_R10: assert property (@(posedge clk)
    !rst_n |-> (grid == '0) && !disp_valid && (digit_idx == '0));
endmodule

bind grid_scan_gen grid_scan_checker #(
  .CLKS_PER_UNIT (CLKS_PER_UNIT),
  .UNITS_PER_SLOT(UNITS_PER_SLOT),
  .NUM_DIGITS    (NUM_DIGITS),
  .DUTY_STEPS    (DUTY_STEPS)
) chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .grid      (grid),
  .digit_idx (digit_idx),
  .disp_valid(disp_valid),
  .unit_tick (unit_tick),
  .frame_end (frame_end),
  .unit_pos  (unit_pos),
  .duty_now  (duty_now),
  .count_now (count_now)
);

// File: tb/sim_grid_scan_gen.sv
`timescale 1ns/1ps
module sim_grid_scan_gen;
  // Timing restated in clocks: unit 8, step 4 units, slot 64 units, frame 16 slots.
  localparam int UNIT_CLKS = 8;
  localparam int STEP_CLKS = 4 * UNIT_CLKS;
  localparam int SLOT_CLKS = 64 * UNIT_CLKS;
  localparam int FRAME     = 16 * SLOT_CLKS;
  localparam int WATCHDOG  = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [3:0]  duty_code = 4'd0;
  logic [3:0]  digit_count = 4'd0;
  logic [15:0] grid;
  logic [3:0]  digit_idx;
  logic        disp_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int mdl_duty = 0;
  int mdl_cnt  = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  grid_scan_gen u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .duty_code  (duty_code),
    .digit_count(digit_count),
    .grid       (grid),
    .digit_idx  (digit_idx),
    .disp_valid (disp_valid)
  );

  // Clock count since reset release and the settings in force per frame.
  always @(posedge clk) begin
    if (!rst_n) begin
      cyc <= 0; mdl_duty <= 0; mdl_cnt <= 0;
    end else begin
      cyc <= cyc + 1;
      if ((cyc + 1) % FRAME == 0) begin
        mdl_duty <= int'(duty_code);
        mdl_cnt  <= int'(digit_count);
      end
    end
  end

  function automatic logic [15:0] want_grid(int t, int duty, int cnt);
    int pos = t % FRAME;
    int d   = pos / SLOT_CLKS;
    int off = pos % SLOT_CLKS;
    bit on  = ((cnt == 0) || (d < cnt)) && (off < duty * STEP_CLKS);
    return on ? (16'h0001 << d) : 16'h0000;
  endfunction

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wait_pos(int p);
    while (cyc % FRAME != p) @(negedge clk);
  endtask

  // Set new settings in the last clock of a frame, step into the next frame.
  task automatic next_frame(int d, int k);
    wait_pos(FRAME - 1);
    duty_code = 4'(d);
    digit_count = 4'(k);
    @(negedge clk);
  endtask

  // Compare one whole frame, starting at its first clock; ends on its last clock.
  task automatic scan_frame(string req);
    int bad = 0;
    logic [15:0] eg;
    logic [15:0] g_bad = '0;
    logic [15:0] e_bad = '0;
    int p_bad = 0;
    for (int i = 0; i < FRAME; i++) begin
      eg = want_grid(cyc, mdl_duty, mdl_cnt);
      if (grid !== eg || disp_valid !== (|eg) ||
          digit_idx !== 4'((cyc % FRAME) / SLOT_CLKS)) begin
        if (bad == 0) begin g_bad = grid; e_bad = eg; p_bad = cyc % FRAME; end
        bad++;
      end
      if (i < FRAME - 1) @(negedge clk);
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s frame scan at clock %0d: actual %h expected %h (%0d bad clocks)",
               req, p_bad, g_bad, e_bad, bad);
    end
  endtask

  task automatic t_reset;
    duty_code = 4'd15; digit_count = 4'd0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", "grid in reset", 32'(grid), 32'h0);
    check("R10", "valid in reset", 32'(disp_valid), 32'h0);
    check("R10", "index in reset", 32'(digit_idx), 32'h0);
    rst_n = 1'b1;
    scan_frame("R10 R9 dark first frame");
  endtask

  task automatic t_full_duty;
    @(negedge clk);
    scan_frame("R5 R7 R8 code 15 all digits");
    @(negedge clk);
    wait_pos(3 * SLOT_CLKS + 479);
    check("R5", "last lit clock", 32'(grid), 32'h0008);
    @(negedge clk);
    check("R5", "first blank clock", 32'(grid), 32'h0);
    check("R5", "valid in blank", 32'(disp_valid), 32'h0);
    wait_pos(15 * SLOT_CLKS + 5);
    check("R7", "sixteenth digit lit", 32'(grid), 32'h8000);
    check("R8", "valid with grid", 32'(disp_valid), 32'h1);
  endtask

  task automatic t_mid_duty;
    next_frame(5, 0);
    scan_frame("R3 code 5");
  endtask

  task automatic t_zero_duty;
    next_frame(0, 0);
    scan_frame("R4 code 0 dark");
  endtask

  task automatic t_count_limit;
    next_frame(8, 3);
    scan_frame("R6 count 3");
  endtask

  task automatic t_late_change;
    @(negedge clk);
    wait_pos(2600);
    duty_code = 4'd12; digit_count = 4'd0;
    wait_pos(9 * SLOT_CLKS + 10);
    check("R9", "slot past old count still dark", 32'(grid), 32'h0);
    @(negedge clk);
    wait_pos(9 * SLOT_CLKS + 10);
    check("R9", "new count applied next frame", 32'(grid), 32'h0200);
    wait_pos(9 * SLOT_CLKS + 384);
    check("R3", "code 12 ends at 384 clocks", 32'(grid), 32'h0);
  endtask

  task automatic t_count_fifteen;
    next_frame(1, 15);
    scan_frame("R6 R3 count 15 code 1");
    @(negedge clk);
    check("R3", "lit at slot start", 32'(grid), 32'h0001);
    begin
      int n = 0;
      while (disp_valid) begin n++; @(negedge clk); end
      check("R3", "code 1 on-time clocks", 32'(n), 32'(STEP_CLKS));
    end
    wait_pos(14 * SLOT_CLKS);
    check("R6", "digit 14 lit", 32'(grid), 32'h4000);
    wait_pos(15 * SLOT_CLKS);
    check("R6", "digit 15 dark", 32'(grid), 32'h0);
    check("R2", "index still reaches 15", 32'(digit_idx), 32'hF);
  endtask

  task automatic t_periods;
    logic [3:0] prev;
    int n;
    wait_pos(100);
    prev = digit_idx;
    while (digit_idx == prev) @(negedge clk);
    prev = digit_idx;
    n = 0;
    do begin @(negedge clk); n++; end while (digit_idx == prev);
    check("R1", "slot length clocks", 32'(n), 32'(SLOT_CLKS));
    while (digit_idx != 4'd15) @(negedge clk);
    while (digit_idx != 4'd0) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (digit_idx != 4'd15);
    do begin @(negedge clk); n++; end while (digit_idx != 4'd0);
    check("R2", "frame length clocks", 32'(n), 32'(FRAME));
  endtask

  initial begin
    t_reset();
    t_full_duty();
    t_mid_duty();
    t_zero_duty();
    t_count_limit();
    t_late_change();
    t_count_fifteen();
    t_periods();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule